// File: doc/BRIEF.md
# Microprogram Sequencer with Control Store

This block is the control section of a horizontally microcoded processor. It holds a 512-word by 36-bit control store and two registers. The microaddress register holds the address of the microinstruction now executing. The microinstruction register holds that word. Each clock cycle the block presents the current word's control fields to a datapath. These are the C-bus write enables, the ALU and shifter bits, the memory strobes, and a one-hot set of B-bus source enables decoded from a 4-bit code. In the same cycle it works out which word runs next.

The next microaddress starts from the word's 9-bit successor field. Conditional branches do not add anything. The N or Z flag from the datapath is ORed into bit 8 of the successor. For a multiway opcode dispatch, the fetched opcode byte is ORed into its low 8 bits. The flags and the opcode byte are sampled at the clock edge that ends the cycle, which is the same edge at which the datapath stores the ALU result. A branch therefore tests the result of the operation in the word that requests it. The store contents are computed from a constant function, so the block needs no external initialisation.

Top module: `useq_top`

## Requirements
- R1: A clock edge with `rst_n` low sets `upc` to 0 and loads the word at address 0, so the outputs show `alu_ctl`=0, `c_wr`=0, all memory strobes low and `b_en`=9'h001.
- R2: The word at address a carries `alu_ctl`=a[7:0], `c_wr`=a[8:0] and {`mem_wr`,`mem_rd`,`mem_fetch`}=a[2:0]. Its B code is a[3:0]. Its successor is a+1 modulo 512 and it has no jump bits, except at these addresses:
  - 0x010: successor 0x020, Z-jump.
  - 0x030: successor 0x040, N-jump.
  - 0x060: successor 0x068, both N-jump and Z-jump.
  - 0x070: successor 0x0C1, opcode-jump.
- R3: Word layout, from the MSB: successor [35:27], opcode-jump [26], N-jump [25], Z-jump [24], ALU/shifter [23:16], C-bus enables [15:7], write [6], read [5], fetch [4], B code [3:0]. The outputs are driven from the register holding the current word.
- R4: With no jump bit set, the next `upc` is the successor field, whatever `flag_n`, `flag_z` and `opcode` are.
- R5: With only the Z-jump bit set, the next `upc` is the successor with bit 8 ORed with `flag_z` as sampled at the closing edge.
- R6: With only the N-jump bit set, the next `upc` is the successor with bit 8 ORed with `flag_n` as sampled at the closing edge.
- R7: With both flag-jump bits set, bit 8 of the next `upc` is the successor's bit 8 ORed with `flag_n` and `flag_z`.
- R8: With the opcode-jump bit set, the low 8 bits of the next `upc` are the successor's low 8 bits ORed (not added) with `opcode` sampled at the closing edge. Example: 0x0C1 with opcode 0x3F gives 0x0FF.
- R9: A B code k below 9 raises only `b_en[k]`. Codes 9 to 15 raise no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_n | input | 1 | ALU negative flag for the current word's operation |
| flag_z | input | 1 | ALU zero flag for the current word's operation |
| opcode | input | 8 | Fetched instruction opcode byte |
| upc | output | 9 | Address of the microinstruction now executing |
| c_wr | output | 9 | C-bus register write enables |
| b_en | output | 9 | One-hot B-bus source enables |
| alu_ctl | output | 8 | ALU and shifter control bits |
| mem_wr | output | 1 | Memory word write strobe |
| mem_rd | output | 1 | Memory word read strobe |
| mem_fetch | output | 1 | Program byte fetch strobe |

## Verification
On every cycle the assertions check the reset address and the next-address rules. For a plain step, each flag-jump variant and the opcode dispatch, they tie each new `upc` to the previous word's successor field and to the flag or opcode values at that edge. They also check that the B enables are at most one-hot and are silent for the unused codes. Only the bench's scenarios can show that the store holds the intended words and that the field positions reach the right ports. The same holds for the flag-jump branches being taken and not taken on separate passes, and for the opcode being ORed rather than added. The bench shows these by following a model program for thousands of cycles, with steered flags and opcodes at the branch words.

// File: rtl/useq_pkg.sv
// Shared types and control-store contents for the microprogram sequencer.
// Assumes a 9-bit microaddress and a 36-bit microinstruction word.
package useq_pkg;

    localparam int UA_W   = 9;   // microaddress width
    localparam int OP_W   = 8;   // opcode byte width
    localparam int ALU_W  = 8;   // ALU / shifter control bits
    localparam int CW_W   = 9;   // C-bus write enables
    localparam int BC_W   = 4;   // encoded B-bus source
    localparam int WORD_W = UA_W + 3 + ALU_W + CW_W + 3 + BC_W;

    // One microinstruction, MSB first.
    typedef struct packed {
        logic [UA_W-1:0]  succ;
        logic             jmpc;
        logic             jamn;
        logic             jamz;
        logic [ALU_W-1:0] alu;
        logic [CW_W-1:0]  cwr;
        logic             mwr;
        logic             mrd;
        logic             mfetch;
        logic [BC_W-1:0]  bsel;
    } uinstr_t;

    // Computes the control-store word held at address a.
    function automatic uinstr_t rom_word(input logic [UA_W-1:0] a);
        uinstr_t w;
        w.succ   = a + 1'b1;
        w.jmpc   = 1'b0;
        w.jamn   = 1'b0;
        w.jamz   = 1'b0;
        w.alu    = a[ALU_W-1:0];
        w.cwr    = a;
        w.mwr    = a[2];
        w.mrd    = a[1];
        w.mfetch = a[0];
        w.bsel   = a[BC_W-1:0];
        case (a)
            9'h010: begin w.succ = 9'h020; w.jamz = 1'b1; end
            9'h030: begin w.succ = 9'h040; w.jamn = 1'b1; end
            9'h060: begin w.succ = 9'h068; w.jamn = 1'b1; w.jamz = 1'b1; end
            9'h070: begin w.succ = 9'h0C1; w.jmpc = 1'b1; end
            default: ;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
// Read-only control store. Every word is computed from useq_pkg::rom_word,
// so no external file is needed. The read path is combinational.
module useq_store
    import useq_pkg::*;
#(
    parameter int ADDR_W = UA_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output uinstr_t           word
);

    uinstr_t rom [DEPTH];

    // Fills each store location from the constant content function.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = rom_word(UA_W'(i));
    end

    // Selects the addressed word.
    assign word = rom[addr];

endmodule

// File: rtl/useq_next.sv
// Next-microaddress logic. It ORs the flags into the top address bit and
// the opcode into the low bits; there is no adder.
// Assumes OP_W < ADDR_W.
module useq_next #(
    parameter int ADDR_W = 9,
    parameter int OP_W   = 8
) (
    input  logic [ADDR_W-1:0] succ,
    input  logic              jmpc,
    input  logic              jamn,
    input  logic              jamz,
    input  logic              n,
    input  logic              z,
    input  logic [OP_W-1:0]   opc,
    output logic [ADDR_W-1:0] nxt
);

    logic              hi_or;
    logic [ADDR_W-1:0] opc_ext;

    // Merges the selected flags and opcode into the successor field.
    always_comb begin
        hi_or   = (jamn & n) | (jamz & z);
        opc_ext = jmpc ? ADDR_W'(opc) : '0;
        nxt     = succ | opc_ext | {hi_or, {(ADDR_W-1){1'b0}}};
    end

endmodule

// File: rtl/useq_bdec.sv
// B-bus source decoder: turns the encoded source into one-hot enables.
// Codes at or above N_SRC select nothing. Assumes N_SRC <= 2**CODE_W.
module useq_bdec #(
    parameter int CODE_W = 4,
    parameter int N_SRC  = 9
) (
    input  logic [CODE_W-1:0] code,
    output logic [N_SRC-1:0]  en
);

    // One comparator per source register.
    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        assign en[k] = (code == CODE_W'(k));
    end

endmodule

// File: rtl/useq_top.sv
// Microprogram sequencer top. It holds the microaddress and microinstruction
// registers. Each edge it loads the word at the computed next address, with
// the flags and opcode sampled at that same edge.
// Assumes the datapath presents flag_n/flag_z for the current word's ALU
// operation before the closing edge.
module useq_top
    import useq_pkg::*;
#(
    parameter int ADDR_W = UA_W,
    parameter int OPC_W  = OP_W,
    parameter int N_BSRC = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] upc,
    output logic [CW_W-1:0]   c_wr,
    output logic [N_BSRC-1:0] b_en,
    output logic [ALU_W-1:0]  alu_ctl,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic              mem_fetch
);

    logic [ADDR_W-1:0] upc_q;
    uinstr_t           mir_q;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] fetch_addr;
    uinstr_t           fetch_word;

    // Next microaddress from the current word, the flags and the opcode.
    useq_next #(.ADDR_W(ADDR_W), .OP_W(OPC_W)) u_next (
        .succ (mir_q.succ),
        .jmpc (mir_q.jmpc),
        .jamn (mir_q.jamn),
        .jamz (mir_q.jamz),
        .n    (flag_n),
        .z    (flag_z),
        .opc  (opcode),
        .nxt  (nxt_addr)
    );

    // Reset forces the fetch to address 0.
    assign fetch_addr = rst_n ? nxt_addr : '0;

    useq_store #(.ADDR_W(ADDR_W)) u_store (
        .addr (fetch_addr),
        .word (fetch_word)
    );

    // Loads the microaddress and microinstruction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc_q <= '0;
            mir_q <= fetch_word;
        end else begin
            upc_q <= fetch_addr;
            mir_q <= fetch_word;
        end
    end

    useq_bdec #(.CODE_W(BC_W), .N_SRC(N_BSRC)) u_bdec (
        .code (mir_q.bsel),
        .en   (b_en)
    );

    // Drives the control fields of the current word.
    assign upc       = upc_q;
    assign c_wr      = mir_q.cwr;
    assign alu_ctl   = mir_q.alu;
    assign mem_wr    = mir_q.mwr;
    assign mem_rd    = mir_q.mrd;
    assign mem_fetch = mir_q.mfetch;

endmodule

// File: rtl/useq_chk.sv
// Assertion checker for useq_top, attached by the bind below.
module useq_chk
    import useq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            flag_n,
    input logic            flag_z,
    input logic [OP_W-1:0] opcode,
    input logic [UA_W-1:0] upc,
    input logic [8:0]      b_en,
    input uinstr_t         mir
);

    // R1: reset returns to microaddress 0.
    assert_reset_addr_R1: assert property (@(posedge clk)
        !rst_n |=> upc == '0);

    // R4: plain step follows the successor field.
    assert_plain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mir.jmpc && !mir.jamn && !mir.jamz) |=> upc == $past(mir.succ));

    // R5: Z-jump ORs the sampled Z flag into bit 8.
    assert_jamz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mir.jmpc && !mir.jamn && mir.jamz) |=>
        (upc[8] == ($past(mir.succ[8]) | $past(flag_z))) &&
        (upc[7:0] == $past(mir.succ[7:0])));

    // R6: N-jump ORs the sampled N flag into bit 8.
    assert_jamn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mir.jmpc && mir.jamn && !mir.jamz) |=>
        (upc[8] == ($past(mir.succ[8]) | $past(flag_n))) &&
        (upc[7:0] == $past(mir.succ[7:0])));

    // R7: both flag jumps OR both flags into bit 8.
    assert_jam_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mir.jmpc && mir.jamn && mir.jamz) |=>
        upc[8] == ($past(mir.succ[8]) | $past(flag_n) | $past(flag_z)));

    // R8: opcode dispatch ORs the opcode into the low bits.
    assert_dispatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mir.jmpc |=> upc[7:0] == ($past(mir.succ[7:0]) | $past(opcode)));

    // R9: source enables are never more than one-hot.
    assert_bus_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_en));

    // R9: unused source codes drive no enable.
    assert_bus_unused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mir.bsel >= 4'd9) |-> b_en == '0);

endmodule

bind useq_top useq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .opcode (opcode),
    .upc    (upc),
    .b_en   (b_en),
    .mir    (mir_q)
);

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flag_n = 1'b0;
    logic       flag_z = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [8:0] upc;
    logic [8:0] c_wr;
    logic [8:0] b_en;
    logic [7:0] alu_ctl;
    logic       mem_wr, mem_rd, mem_fetch;

    int    checks = 0;
    int    failures = 0;
    int    m_upc = 0;
    string m_tag = "R1";
    int    pass_k = 0;
    int    hit_z_taken = 0, hit_z_not = 0, hit_n_taken = 0, hit_n_not = 0;
    int    hit_both = 0, hit_disp_or = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    useq_top u0 (
        .clk(clk), .rst_n(rst_n), .flag_n(flag_n), .flag_z(flag_z),
        .opcode(opcode), .upc(upc), .c_wr(c_wr), .b_en(b_en),
        .alu_ctl(alu_ctl), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_fetch(mem_fetch)
    );

    // Model program: successor and jump kind (bit2 opcode, bit1 N, bit0 Z).
    function automatic int succ_of(int a);
        if (a == 'h010) return 'h020;
        if (a == 'h030) return 'h040;
        if (a == 'h060) return 'h068;
        if (a == 'h070) return 'h0C1;
        return (a + 1) % 512;
    endfunction

    function automatic int jump_of(int a);
        if (a == 'h010) return 1;
        if (a == 'h030) return 2;
        if (a == 'h060) return 3;
        if (a == 'h070) return 4;
        return 0;
    endfunction

    function automatic int exp_ben(int a);
        int code = a % 16;
        return (code < 9) ? (1 << code) : 0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s upc_model=%03h actual=%0h expected=%0h", tag, m_upc, act, exp);
        end
    endtask

    // Advances the model at a rising edge using the inputs then present.
    task automatic model_step();
        int j, nx;
        if (!rst_n) begin
            m_upc = 0;
            m_tag = "R1";
            return;
        end
        j  = jump_of(m_upc);
        nx = succ_of(m_upc);
        if (j == 1) begin m_tag = "R5"; if (flag_z) begin nx |= 256; hit_z_taken++; end else hit_z_not++; end
        else if (j == 2) begin m_tag = "R6"; if (flag_n) begin nx |= 256; hit_n_taken++; end else hit_n_not++; end
        else if (j == 3) begin m_tag = "R7"; if (flag_n | flag_z) begin nx |= 256; hit_both++; end end
        else if (j == 4) begin
            m_tag = "R8";
            if ((nx + opcode) != (nx | opcode)) hit_disp_or++;
            nx |= opcode;
        end
        else m_tag = "R4";
        m_upc = nx;
    endtask

    // Compares every output against the model word.
    task automatic compare_all();
        chk(m_tag, upc, m_upc);
        chk("R9", b_en, exp_ben(m_upc));
        chk("R2/R3 alu", alu_ctl, m_upc % 256);
        chk("R2/R3 cwr", c_wr, m_upc);
        chk("R2/R3 mem", {mem_wr, mem_rd, mem_fetch}, m_upc % 8);
    endtask

    // Sets flags and opcode: noise elsewhere, steered at the branch words.
    task automatic drive();
        lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        flag_n = lfsr[0];
        flag_z = lfsr[5];
        opcode = lfsr[15:8];
        if (m_upc == 'h010) flag_z = (pass_k % 5 == 1);
        if (m_upc == 'h030) flag_n = (pass_k % 5 == 2);
        if (m_upc == 'h060) begin flag_n = (pass_k % 5 == 3); flag_z = (pass_k % 5 == 4); end
        if (m_upc == 'h070) opcode = (pass_k == 0) ? 8'h3F : 8'((pass_k * 41) ^ 63);
    endtask

    initial begin
        // R1: reset state.
        repeat (2) begin
            @(posedge clk); model_step();
            @(negedge clk); compare_all();
        end
        chk("R1 reset b_en", b_en, 1);
        rst_n = 1'b1;
        drive();
        for (int i = 0; i < 22000; i++) begin
            @(posedge clk); model_step();
            @(negedge clk); compare_all();
            if (m_upc == 0) pass_k++;
            if (i == 15000) rst_n = 1'b0;
            if (i == 15002) rst_n = 1'b1;
            drive();
        end
        chk("R5 z taken seen", int'(hit_z_taken > 0), 1);
        chk("R5 z not taken seen", int'(hit_z_not > 0), 1);
        chk("R6 n taken seen", int'(hit_n_taken > 0), 1);
        chk("R6 n not taken seen", int'(hit_n_not > 0), 1);
        chk("R7 either flag seen", int'(hit_both > 1), 1);
        chk("R8 or-not-add seen", int'(hit_disp_or > 0), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule